// File: doc/BRIEF.md
# Divider Alignment Pulse Controller

Two divide-by-8 clock dividers run from the same fast clock but have no reset, so after power-up their count phases differ by an arbitrary amount. This block brings them into step by removing input counts from one divider only. Channel A is the reference and always counts. Channel B can be held off by a gate pulse.

A single sync request starts a correction loop. The controller raises the channel-B gate for a fixed window of 7 fast cycles, during which divider B stops counting. It then waits a short settle window and compares the two counts. If they match, the loop ends and the aligned flag is raised. If they do not match, another pulse follows at once. After a set number of pulses without a match, the loop gives up and raises an error flag.

Gating is modelled as a count enable inside the fast clock domain. The arbitrary power-up phase of each divider is supplied as an input and is loaded while reset is held.

Top module: `dclk_align_ctrl`

## Requirements
- R1: While reset is applied, each divider loads its phase input as its 3-bit count. After reset, busy, aligned, sync_err, gate_a and gate_b are all low.
- R2: Each divided output is bit 2 of its divider's 3-bit count, so it has a period of 8 fast cycles. Divider A counts on every fast cycle.
- R3: A sync request sampled while idle starts a sequence. Busy is high from the next cycle until the sequence ends.
- R4: Each gate pulse holds gate_b high for exactly 7 consecutive fast cycles, and divider B does not count during those cycles. gate_a is never high.
- R5: The two counts are compared in the 4th fast cycle after the gate falls. On a match the sequence ends with aligned high. With d = (phase_a - phase_b) mod 8, a sequence takes d pulses, or 8 pulses when d is 0, and lasts 11 cycles per pulse.
- R6: On a mismatch below the pulse limit, the next gate pulse starts in the cycle after the compare.
- R7: On a mismatch after MAX_PULSES pulses, the sequence ends with sync_err high and aligned low. A match on the last permitted pulse ends with aligned high and no error.
- R8: A sync request while busy is ignored. The pulse count and the sequence length are unchanged.
- R9: aligned and sync_err hold their values until the next accepted request, which clears both. They are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| phase_init_a | input | 3 | Power-up count of divider A, loaded during reset |
| phase_init_b | input | 3 | Power-up count of divider B, loaded during reset |
| sync_req | input | 1 | Request to start an alignment sequence |
| div_a | output | 1 | Divided clock of channel A |
| div_b | output | 1 | Divided clock of channel B |
| gate_a | output | 1 | Count-suppress gate for channel A (reference, never driven high) |
| gate_b | output | 1 | Count-suppress gate for channel B |
| busy | output | 1 | Sequence in progress |
| aligned | output | 1 | Last sequence ended with equal counts |
| sync_err | output | 1 | Last sequence hit the pulse limit without a match |

## Verification
Two events can fall in the same cycle here.

- **Compare and pulse limit.** The settle-window compare that finds a match can coincide with the pulse-limit decision. The bench provokes this with a second instance limited to 3 pulses and sweeps every pair of start phases, so d = 3 lands exactly on the limit. That case must end aligned with no error, while d above 3 must end in error after 21 gate cycles.
- **Request while busy.** Every run also drives a fresh request into the middle of the first gate pulse. The bench judges that it was ignored from the total gate-high and busy cycle counts, which must still equal 7 and 11 cycles per expected pulse.

// File: rtl/dclk_align_pkg.sv
package dclk_align_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATE   = 2'd1,
    ST_SETTLE = 2'd2
  } seq_state_t;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/dclk_divider.sv
module dclk_divider #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic [CNT_W-1:0] init_cnt,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] cnt,
  output logic             div_clk
);

  logic [CNT_W-1:0] cnt_r;
  logic [CNT_W-1:0] cnt_nxt;

  // No reset flop: the count takes its power-up phase while reset is held.
  always_comb begin
    if (!rst_q_n)    cnt_nxt = init_cnt;
    else if (cnt_en) cnt_nxt = cnt_r + CNT_W'(1);
    else             cnt_nxt = cnt_r;
  end

  always_ff @(posedge clk) begin
    cnt_r <= cnt_nxt;
  end

  assign cnt     = cnt_r;
  assign div_clk = cnt_r[CNT_W-1];

  AST_HOLD_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cnt_en |=> $stable(cnt_r)); // R4

endmodule

// File: rtl/dclk_phase_cmp.sv
module dclk_phase_cmp #(
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0] cnt_ref,
  input  logic [CNT_W-1:0] cnt_adj,
  output logic             match
);

  always_comb begin
    match = (cnt_ref == cnt_adj);
  end

endmodule

// File: rtl/dclk_pulse_fsm.sv
module dclk_pulse_fsm
  import dclk_align_pkg::*;
#(
  parameter int GATE_LEN   = 7,
  parameter int SETTLE_LEN = 4,
  parameter int MAX_PULSES = 8
) (
  input  logic clk,
  input  logic rst_q_n,
  input  logic sync_req,
  input  logic phase_match,
  output logic gate_o,
  output logic busy_o,
  output logic aligned_o,
  output logic err_o
);

  localparam int TMR_MAX = (GATE_LEN > SETTLE_LEN) ? GATE_LEN : SETTLE_LEN;
  localparam int TMR_W   = $clog2(TMR_MAX) + 1;
  localparam int NP_W    = $clog2(MAX_PULSES + 1);

  seq_state_t        state_q, state_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [NP_W-1:0]   np_q, np_d;
  logic              aligned_q, aligned_d;
  logic              err_q, err_d;

  logic gate_last;
  logic settle_last;
  logic at_limit;

  assign gate_last   = (tmr_q == TMR_W'(GATE_LEN - 1));
  assign settle_last = (tmr_q == TMR_W'(SETTLE_LEN - 1));
  assign at_limit    = (np_q >= NP_W'(MAX_PULSES));

  always_comb begin
    state_d   = state_q;
    tmr_d     = tmr_q;
    np_d      = np_q;
    aligned_d = aligned_q;
    err_d     = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (sync_req) begin
          state_d   = ST_GATE;
          tmr_d     = '0;
          np_d      = NP_W'(1);
          aligned_d = 1'b0;
          err_d     = 1'b0;
        end
      end
      ST_GATE: begin
        if (gate_last) begin
          state_d = ST_SETTLE;
          tmr_d   = '0;
        end else begin
          tmr_d = tmr_q + TMR_W'(1);
        end
      end
      ST_SETTLE: begin
        if (settle_last) begin
          tmr_d = '0;
          if (phase_match) begin
            state_d   = ST_IDLE;
            aligned_d = 1'b1;
          end else if (at_limit) begin
            state_d = ST_IDLE;
            err_d   = 1'b1;
          end else begin
            state_d = ST_GATE;
            np_d    = np_q + NP_W'(1);
          end
        end else begin
          tmr_d = tmr_q + TMR_W'(1);
        end
      end
      default: begin
        state_d = ST_IDLE;
        tmr_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q   <= ST_IDLE;
      tmr_q     <= '0;
      np_q      <= '0;
      aligned_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      tmr_q     <= tmr_d;
      np_q      <= np_d;
      aligned_q <= aligned_d;
      err_q     <= err_d;
    end
  end

  assign gate_o    = (state_q == ST_GATE);
  assign busy_o    = (state_q != ST_IDLE);
  assign aligned_o = aligned_q;
  assign err_o     = err_q;

  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(busy_o) |-> $past(sync_req)); // R3

  AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_q_n)
    np_q <= NP_W'(MAX_PULSES)); // R7

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(aligned_q && err_q)); // R9

  AST_REQ_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy_o && sync_req) |=> (busy_o && !aligned_o && !err_o)); // R9

  AST_BUSY_REQ_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy_o && sync_req && np_q != '0) |=> (np_q >= $past(np_q))); // R8

endmodule

// File: rtl/dclk_align_ctrl.sv
module dclk_align_ctrl
  import dclk_align_pkg::*;
#(
  parameter int                 CNT_W      = 3,
  parameter int                 GATE_LEN   = 7,
  parameter int                 SETTLE_LEN = 4,
  parameter int                 MAX_PULSES = 8,
  parameter logic [NUM_CH-1:0]  GATED_MASK = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] phase_init_a,
  input  logic [CNT_W-1:0] phase_init_b,
  input  logic             sync_req,
  output logic             div_a,
  output logic             div_b,
  output logic             gate_a,
  output logic             gate_b,
  output logic             busy,
  output logic             aligned,
  output logic             sync_err
);

  localparam int RUN_W = $clog2(GATE_LEN + 1) + 1;

  // Reset: asserted at once, released on the second clock edge.
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  logic [CNT_W-1:0] init_ch [NUM_CH];
  logic [CNT_W-1:0] cnt_ch  [NUM_CH];
  logic [NUM_CH-1:0] div_ch;
  logic [NUM_CH-1:0] gate_ch;
  logic              fsm_gate;
  logic              phase_match;

  assign init_ch[0] = phase_init_a;
  assign init_ch[1] = phase_init_b;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    if (GATED_MASK[ch]) begin : g_gated
      assign gate_ch[ch] = fsm_gate;
    end else begin : g_free
      assign gate_ch[ch] = 1'b0;
    end

    dclk_divider #(.CNT_W(CNT_W)) u_div (
      .clk      (clk),
      .rst_q_n  (rst_q_n),
      .init_cnt (init_ch[ch]),
      .cnt_en   (~gate_ch[ch]),
      .cnt      (cnt_ch[ch]),
      .div_clk  (div_ch[ch])
    );
  end

  dclk_phase_cmp #(.CNT_W(CNT_W)) u_cmp (
    .cnt_ref (cnt_ch[0]),
    .cnt_adj (cnt_ch[1]),
    .match   (phase_match)
  );

  dclk_pulse_fsm #(
    .GATE_LEN   (GATE_LEN),
    .SETTLE_LEN (SETTLE_LEN),
    .MAX_PULSES (MAX_PULSES)
  ) u_fsm (
    .clk         (clk),
    .rst_q_n     (rst_q_n),
    .sync_req    (sync_req),
    .phase_match (phase_match),
    .gate_o      (fsm_gate),
    .busy_o      (busy),
    .aligned_o   (aligned),
    .err_o       (sync_err)
  );

  assign div_a  = div_ch[0];
  assign div_b  = div_ch[1];
  assign gate_a = gate_ch[0];
  assign gate_b = gate_ch[1];

  // Checker state: length of the current gate-high run.
  logic [RUN_W-1:0] gate_run_q;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    gate_run_q <= '0;
    else if (gate_b) gate_run_q <= gate_run_q + RUN_W'(1);
    else             gate_run_q <= '0;
  end

  AST_GATE_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(gate_b) |-> (gate_run_q == RUN_W'(GATE_LEN))); // R4

  AST_ALIGNED_MATCH: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(aligned) |-> (cnt_ch[0] == cnt_ch[1])); // R5

  AST_GATE_ONLY_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(gate_b) |-> (busy && !aligned && !sync_err)); // R6

endmodule

// File: tb/dclk_align_ctrl_bench.sv
`timescale 1ns/1ps
module dclk_align_ctrl_bench;

  logic       clk;
  logic       rst_n;
  logic [2:0] init_a, init_b;
  logic       sync_req;
  logic       div_a, div_b, gate_a, gate_b, busy, aligned, sync_err;
  logic       l_div_a, l_div_b, l_gate_a, l_gate_b, l_busy, l_aligned, l_err;

  int checks   = 0;
  int failures = 0;
  localparam int LIM = 3;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  dclk_align_ctrl u_dclk_align_ctrl (
    .clk(clk), .rst_n(rst_n), .phase_init_a(init_a), .phase_init_b(init_b),
    .sync_req(sync_req), .div_a(div_a), .div_b(div_b), .gate_a(gate_a),
    .gate_b(gate_b), .busy(busy), .aligned(aligned), .sync_err(sync_err)
  );

  dclk_align_ctrl #(.MAX_PULSES(LIM)) u_lim (
    .clk(clk), .rst_n(rst_n), .phase_init_a(init_a), .phase_init_b(init_b),
    .sync_req(sync_req), .div_a(l_div_a), .div_b(l_div_b), .gate_a(l_gate_a),
    .gate_b(l_gate_b), .busy(l_busy), .aligned(l_aligned), .sync_err(l_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (init_a=%0d init_b=%0d)",
               req, act, exp, init_a, init_b);
    end
  endtask

  // Runs one sequence on both instances; returns cycle counts at negedges.
  task automatic run_seq(output int bm, output int gm, output int ga,
                         output int bl, output int gl);
    bm = 0; gm = 0; ga = 0; bl = 0; gl = 0;
    sync_req = 1'b1;
    @(negedge clk);
    sync_req = 1'b0;
    chk(busy == 1'b1, "R3 busy after request", int'(busy), 1);
    for (int c = 0; c < 400; c++) begin
      if (busy)     bm++;
      if (gate_b)   gm++;
      if (gate_a || l_gate_a) ga++;
      if (l_busy)   bl++;
      if (l_gate_b) gl++;
      sync_req = (c == 5);  // R8: request while busy
      if (!busy && !l_busy) break;
      @(negedge clk);
    end
    sync_req = 1'b0;
  endtask

  initial begin
    int bm, gm, ga, bl, gl;
    rst_n = 1'b0; sync_req = 1'b0; init_a = '0; init_b = '0;
    for (int ia = 0; ia < 8; ia++) begin
      for (int ib = 0; ib < 8; ib++) begin
        int d, k, kl;
        bit l_ok;
        @(negedge clk);
        init_a = 3'(ia); init_b = 3'(ib); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!busy && !aligned && !sync_err && !gate_b && !gate_a,
            "R1 reset outputs", int'({busy, aligned, sync_err, gate_b, gate_a}), 0);
        d  = (ia - ib + 8) % 8;
        k  = (d == 0) ? 8 : d;
        l_ok = (k <= LIM);
        kl = l_ok ? k : LIM;
        run_seq(bm, gm, ga, bl, gl);
        chk(gm == 7 * k, "R4 gate cycles", gm, 7 * k);
        chk(bm == 11 * k, "R5/R6/R8 busy cycles", bm, 11 * k);
        chk(ga == 0, "R4 gate_a stays low", ga, 0);
        chk(aligned && !sync_err, "R5 aligned flag", int'({aligned, sync_err}), 2);
        chk(gl == 7 * kl, "R7 limited gate cycles", gl, 7 * kl);
        chk(bl == 11 * kl, "R7 limited busy cycles", bl, 11 * kl);
        chk(l_aligned == l_ok && l_err == !l_ok, "R7 limited flags",
            int'({l_aligned, l_err}), l_ok ? 2 : 1);
        for (int c = 0; c < 16; c++) begin
          @(negedge clk);
          if (div_a != div_b || !aligned) begin
            chk(1'b0, "R5/R9 outputs match and flag held",
                int'({div_a, div_b, aligned}), int'({div_a, div_a, 1'b1}));
            break;
          end
        end
        chk(aligned == 1'b1, "R9 aligned held", int'(aligned), 1);
      end
    end

    // R2: divided output period of 8 fast cycles.
    begin
      int per;
      per = 0;
      while (!(div_a == 1'b0)) @(negedge clk);
      while (div_a == 1'b0) @(negedge clk);
      @(negedge clk);
      per = 1;
      while (!(div_a == 1'b0)) begin @(negedge clk); per++; end
      while (div_a == 1'b0) begin @(negedge clk); per++; end
      chk(per == 8, "R2 div_a period", per, 8);
      chk(div_b == div_a, "R2 div_b follows", int'(div_b), int'(div_a));
    end

    // R9: a new request clears aligned; aligned start means d=0 -> 8 pulses.
    sync_req = 1'b1;
    @(negedge clk);
    sync_req = 1'b0;
    chk(!aligned && busy, "R9 request clears aligned", int'({aligned, busy}), 1);
    gm = 1;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (!busy) break;
      if (gate_b) gm++;
    end
    chk(gm == 56, "R5 zero-offset takes 8 pulses", gm, 56);
    chk(aligned == 1'b1, "R5 realigned", int'(aligned), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule